// File: doc/BRIEF.md
# Dual Gated One-Shot Pulse Generator

This block holds a number of independent one-shot channels, two by default. Each channel produces one output pulse of programmable length when one of its trigger inputs makes a qualifying transition. The inputs are an active-low trigger, an active-high trigger and an active-low clear. The outputs are a pulse and its complement. The pulse length is a cycle count, given per channel, and it stands in for a timing network.

All inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer. Edges are found by comparing the synchronized level with its value on the previous cycle.

There are three trigger conditions:
- a rising edge on the high trigger while the low trigger is low;
- a falling edge on the low trigger while the high trigger is high;
- a rising edge on the clear itself while the low trigger is low and the high trigger is high.

Clear held low forces the channel idle and cuts short any running pulse. A channel that is already pulsing ignores further qualifying edges. The length is captured when the pulse starts, so later changes to the length input do not affect a running pulse.

Top module: `dual_oneshot`

## Requirements
- R1: With clr_n high and trig_a_n low, a rising edge on trig_b starts a pulse.
- R2: With clr_n and trig_b high, a falling edge on trig_a_n starts a pulse.
- R3: With trig_a_n low and trig_b high, a rising edge on clr_n starts a pulse.
- R4: While clr_n is low the channel is idle (q low, q_n high), and a pulse in progress ends on the third clock edge after clr_n falls.
- R5: q_n is always the inverse of q. q is 1 exactly while a pulse is running.
- R6: Edges that do not meet a trigger condition start nothing. Examples are a trig_b rise with trig_a_n high, a trig_a_n rise, and a clr_n rise with trig_a_n high.
- R7: A pulse lasts exactly N clock cycles. N is the channel's 16-bit pulse_len field, sampled when the pulse starts; a value of 0 gives 1 cycle. Channel k uses bits [16k+15:16k].
- R8: Qualifying edges that arrive while a pulse is running are ignored. The pulse is neither restarted nor lengthened.
- R9: The channels are fully independent: stimulus on one never changes the other's outputs.
- R10: q rises after the third rising clock edge that follows a trigger input change: two synchronizer stages, then the start cycle.
- R11: A synchronous active-low reset puts every channel idle at the next clock edge, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_a_n | input | NCH | Active-low trigger, one bit per channel |
| trig_b | input | NCH | Active-high trigger, one bit per channel |
| clr_n | input | NCH | Active-low clear, one bit per channel |
| pulse_len | input | NCH*16 | Pulse length in cycles, 16 bits per channel |
| q | output | NCH | Pulse output, one bit per channel |
| q_n | output | NCH | Complement of q |

## Verification
The hardest situation to reach is a qualifying edge that lands while a pulse is already running. The same input must first start the pulse, then fall and rise again within the pulse window, and the count must still end on time. The stimulus starts a ten-cycle pulse and drops and raises trig_b in the middle of it, so that the second rise passes through the synchronizer while the counter is still busy. It then checks that the total high time is still ten cycles. A similar timed sequence raises clr_n mid-pulse on the other channel, and another changes pulse_len after the start.

// File: rtl/oneshot_pkg.sv
// Package: shared types for the one-shot channels.
// Assumes each channel samples three trigger levels per cycle.
package oneshot_pkg;
    // Synchronized trigger levels of one channel.
    typedef struct packed {
        logic a_n;
        logic b;
        logic clr_n;
    } trig_lvl_t;

    localparam int unsigned LVL_W = $bits(trig_lvl_t);

    // Level pattern that can never produce a qualifying edge.
    localparam trig_lvl_t LVL_IDLE = '{a_n: 1'b1, b: 1'b0, clr_n: 1'b1};
endpackage

// File: rtl/os_sync.sv
// Module: os_sync
// Two-flop synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is sampled on its own; no cross-bit coherence is given.
module os_sync #(
    parameter int unsigned    W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two sampling stages; reset loads a value that cannot look like an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/os_edge_qual.sv
// Module: os_edge_qual
// Finds edges on the synchronized trigger levels and qualifies them
// against the three trigger conditions.
// Assumes cur comes straight from the synchronizer.
// start is combinational and is valid in the cycle the edge is seen.
module os_edge_qual
    import oneshot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trig_lvl_t cur,
    output logic      start,
    output logic      clr_ok
);
    trig_lvl_t prev;
    logic      rise_b;
    logic      fall_a;
    logic      rise_clr;

    // Hold the previous cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= LVL_IDLE;
        else        prev <= cur;
    end

    // Qualify each edge type with the levels of the other two inputs.
    always_comb begin
        rise_b   = cur.b & ~prev.b;
        fall_a   = ~cur.a_n & prev.a_n;
        rise_clr = cur.clr_n & ~prev.clr_n;
        start    = (cur.clr_n & ((rise_b & ~cur.a_n) | (fall_a & cur.b)))
                 | (rise_clr & ~cur.a_n & cur.b);
        clr_ok   = cur.clr_n;
    end
endmodule

// File: rtl/os_timer.sv
// Module: os_timer
// Non-retriggerable pulse down-counter for one channel.
// Assumes start and clr_ok come from os_edge_qual in the same cycle.
// The length is captured on start, and 0 is treated as 1.
module os_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             clr_ok,
    input  logic [CNT_W-1:0] width,
    output logic             active
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Load on an idle start, count down while active, drop on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!clr_ok) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            if (cnt <= ONE) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt - ONE;
            end
        end else if (start) begin
            active <= 1'b1;
            cnt    <= (width == '0) ? ONE : width;
        end
    end

    AST_CLR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_ok |=> !active);                                            // R4
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && clr_ok && !active) |=> (active && cnt != '0));          // R7
    AST_LAST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && clr_ok && cnt == ONE) |=> !active);                    // R7
    AST_NO_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (active && clr_ok && cnt > ONE) |=> (active && cnt == $past(cnt) - ONE)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> cnt == '0);                                           // R11
endmodule

// File: rtl/dual_oneshot.sv
// Module: dual_oneshot
// Top of the multi-channel gated one-shot.
// Each channel has its own synchronizer, edge qualifier and timer.
// Assumes the pulse_len fields are quasi-static around trigger events.
module dual_oneshot
    import oneshot_pkg::*;
#(
    parameter int unsigned NCH   = 2,
    parameter int unsigned CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       trig_a_n,
    input  logic [NCH-1:0]       trig_b,
    input  logic [NCH-1:0]       clr_n,
    input  logic [NCH*CNT_W-1:0] pulse_len,
    output logic [NCH-1:0]       q,
    output logic [NCH-1:0]       q_n
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        trig_lvl_t raw_lvl;
        trig_lvl_t sync_lvl;
        logic      start;
        logic      clr_ok;
        logic      active;

        // Gather this channel's raw input levels.
        always_comb begin
            raw_lvl.a_n   = trig_a_n[ch];
            raw_lvl.b     = trig_b[ch];
            raw_lvl.clr_n = clr_n[ch];
        end

        os_sync #(.W(LVL_W), .RST_VAL(LVL_IDLE)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_lvl),
            .q     (sync_lvl)
        );

        os_edge_qual u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .cur    (sync_lvl),
            .start  (start),
            .clr_ok (clr_ok)
        );

        os_timer #(.CNT_W(CNT_W)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (start),
            .clr_ok (clr_ok),
            .width  (pulse_len[ch*CNT_W +: CNT_W]),
            .active (active)
        );

        // Drive the complementary outputs from the registered pulse state.
        always_comb begin
            q[ch]   = active;
            q_n[ch] = ~active;
        end
    end
endmodule

// File: tb/sim_dual_oneshot.sv
module sim_dual_oneshot;
    localparam int CW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  a_n = 2'b11;
    logic [1:0]  b = 2'b00;
    logic [1:0]  clr_n = 2'b11;
    logic [31:0] wid = '0;
    logic [1:0]  q;
    logic [1:0]  q_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    dual_oneshot u0 (
        .clk(clk), .rst_n(rst_n), .trig_a_n(a_n), .trig_b(b), .clr_n(clr_n),
        .pulse_len(wid), .q(q), .q_n(q_n)
    );

    // Level codes {a_n, b, clr_n}
    typedef struct packed {
        logic        ch;
        logic [2:0]  pre;
        logic [2:0]  post;
        logic [15:0] w;
        logic [15:0] len;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'b001, 3'b011, 16'd5, 16'd5},   // R1 ch0
        '{1'b0, 3'b111, 3'b011, 16'd3, 16'd3},   // R2 ch0
        '{1'b0, 3'b010, 3'b011, 16'd4, 16'd4},   // R3 ch0
        '{1'b1, 3'b001, 3'b011, 16'd7, 16'd7},   // R1 ch1
        '{1'b1, 3'b111, 3'b011, 16'd0, 16'd1},   // R2 ch1, R7 zero length
        '{1'b1, 3'b010, 3'b011, 16'd1, 16'd1},   // R3 ch1
        '{1'b0, 3'b101, 3'b111, 16'd4, 16'd0},   // R6 b rises, a high
        '{1'b0, 3'b001, 3'b101, 16'd4, 16'd0},   // R6 a rises
        '{1'b1, 3'b110, 3'b111, 16'd4, 16'd0}    // R6 clr rises, a high
    };

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_lv(int ch, logic [2:0] l);
        a_n[ch]   = l[2];
        b[ch]     = l[1];
        clr_n[ch] = l[0];
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(int ch, int ncyc, output int first, output int len,
                           output int other_hi, output int cerr);
        first = 0; len = 0; other_hi = 0; cerr = 0;
        for (int i = 1; i <= ncyc; i++) begin
            @(negedge clk);
            if (q[ch]) begin
                len++;
                if (first == 0) first = i;
            end
            if (q[1-ch]) other_hi++;
            if (q_n !== ~q) cerr++;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=50000 cycles", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int first, len, oth, cerr;

        // R11: reset state
        wait_n(3);
        check("R11 reset q", int'(q), 0);
        check("R11 reset q_n", int'(q_n), 3);
        rst_n = 1'b1;
        wait_n(4);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            wid[VECS[v].ch*CW +: CW] = VECS[v].w;
            set_lv(VECS[v].ch, VECS[v].pre);
            wait_n(6);
            check($sformatf("R6 pre vec%0d", v), int'(q[VECS[v].ch]), 0);
            set_lv(VECS[v].ch, VECS[v].post);
            measure(VECS[v].ch, 30, first, len, oth, cerr);
            check($sformatf("R7 length vec%0d", v), len, int'(VECS[v].len));
            if (VECS[v].len != 0)
                check($sformatf("R10 latency vec%0d", v), first, 3);
            check($sformatf("R9 other channel vec%0d", v), oth, 0);
            check($sformatf("R5 complement vec%0d", v), cerr, 0);
            set_lv(VECS[v].ch, 3'b101);
            wait_n(6);
        end

        // R4: clear cuts a running pulse short, with three-edge latency
        wid[CW-1:0] = 16'd20;
        set_lv(0, 3'b001);
        wait_n(6);
        set_lv(0, 3'b011);
        wait_n(6);
        check("R4 pulse running before clear", int'(q[0]), 1);
        clr_n[0] = 1'b0;
        wait_n(2);
        check("R10 clear latency q still high", int'(q[0]), 1);
        wait_n(1);
        check("R4 clear ends pulse q", int'(q[0]), 0);
        check("R4 clear q_n", int'(q_n[0]), 1);
        a_n[0] = 1'b1;
        b[0] = 1'b0;
        wait_n(25);
        check("R4 held idle under clear", int'(q[0]), 0);
        clr_n[0] = 1'b1;
        wait_n(6);
        check("R6 clear release with a high", int'(q[0]), 0);

        // R8: a second qualifying edge mid-pulse is ignored
        wid[CW-1:0] = 16'd10;
        set_lv(0, 3'b001);
        wait_n(6);
        set_lv(0, 3'b011);
        len = 0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (q[0]) len++;
            if (i == 5) b[0] = 1'b0;
            if (i == 7) b[0] = 1'b1;
        end
        check("R8 no retrigger length", len, 10);
        set_lv(0, 3'b101);
        wait_n(6);

        // R7: length captured at start; later changes ignored
        wid[CW +: CW] = 16'd6;
        set_lv(1, 3'b001);
        wait_n(6);
        set_lv(1, 3'b011);
        len = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (q[1]) len++;
            if (i == 4) wid[CW +: CW] = 16'd2;
        end
        check("R7 captured length", len, 6);
        set_lv(1, 3'b101);
        wait_n(6);

        // R9: both channels at once, different lengths
        wid = {16'd9, 16'd4};
        set_lv(0, 3'b001);
        set_lv(1, 3'b001);
        wait_n(6);
        set_lv(0, 3'b011);
        set_lv(1, 3'b011);
        first = 0;
        len = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (q[0]) first++;
            if (q[1]) len++;
        end
        check("R9 simultaneous ch0 length", first, 4);
        check("R9 simultaneous ch1 length", len, 9);
        set_lv(0, 3'b101);
        set_lv(1, 3'b101);
        wait_n(6);

        // R9: clearing ch1 does not disturb ch0
        wid[CW-1:0] = 16'd12;
        set_lv(0, 3'b001);
        wait_n(6);
        set_lv(0, 3'b011);
        len = 0;
        oth = 0;
        for (int i = 1; i <= 25; i++) begin
            @(negedge clk);
            if (q[0]) len++;
            if (q[1]) oth++;
            if (i == 4) clr_n[1] = 1'b0;
            if (i == 8) clr_n[1] = 1'b1;
        end
        check("R9 ch0 unaffected by ch1 clear", len, 12);
        check("R9 ch1 stays idle", oth, 0);
        set_lv(0, 3'b101);
        wait_n(6);

        // R11: reset in the middle of a pulse
        wid[CW +: CW] = 16'd20;
        set_lv(1, 3'b001);
        wait_n(6);
        set_lv(1, 3'b011);
        wait_n(6);
        check("R11 pulse running before reset", int'(q[1]), 1);
        rst_n = 1'b0;
        wait_n(1);
        check("R11 reset ends pulse", int'(q[1]), 0);
        set_lv(1, 3'b101);
        wait_n(3);
        rst_n = 1'b1;
        wait_n(8);
        check("R11 idle after reset release", int'(q), 0);

        summary();
        $finish;
    end
endmodule